// File: doc/BRIEF.md
# Block Prediction Error and Pixel Transfer Evaluator

This block scores one 16x16 tile of 8-bit grayscale pixels against an external predictor. The tile is first written into a local buffer through a simple write port. After a start pulse the block visits every pixel in raster order. For each pixel it fetches the four causal neighbours (upper-left, upper, upper-right, left) and presents them to an outside predictor. It waits for the predicted value and compares it with the stored pixel.

Each tile quarter has its own error threshold. A pixel whose absolute error is strictly above its quarter's threshold is sent out as a key pixel, carrying its position and original value, and it adds nothing to the error sum. This holds only while the number of key pixels sent stays below a programmable maximum. After that point, over-threshold pixels are summed like any other pixel and a sticky overflow flag is raised. At the end a one-cycle done strobe marks the final error sum, key pixel count and overflow flag. A fitness engine upstream turns these into a score.

Top module: `blkpred_eval`

## Requirements
- R1: After reset, busy, pred_req, xfer_valid and done are 0, and err_sum, xfer_count and xfer_ovf are 0.
- R2: Pixels are visited in raster order, index p = {row[3:0], col[3:0]}, for 256 predictor requests per scan. While pred_req is high, nb_ul/nb_up/nb_ur/nb_lf hold the pixels at (row-1,col-1), (row-1,col), (row-1,col+1) and (row,col-1), and they stay stable until pred_ack. A neighbour outside the tile reads as 0.
- R3: err_sum is the sum of |prediction - pixel| over all pixels that are not transferred, kept in a 16-bit register.
- R4: The quarter index is {row[3], col[3]}. Quarter k uses q_thresh[8k+7:8k]: 0 is top-left, 1 top-right, 2 bottom-left, 3 bottom-right.
- R5: A pixel with an error strictly greater than its threshold is transferred while xfer_count < xfer_max. It is emitted with xfer_pos = {row,col} and xfer_pix = original value, it adds 0 to err_sum, and it increments xfer_count.
- R6: When xfer_count has reached xfer_max, an over-threshold pixel is not transferred. Its error is added to err_sum and xfer_ovf is set and stays set until the next start.
- R7: xfer_valid stays high with a stable payload until xfer_ready is high. No further predictor request is made while a transfer waits.
- R8: done pulses for one cycle after the last pixel, with busy low. err_sum, xfer_count and xfer_ovf then hold their values until the next start.
- R9: Buffer writes (ld_en) are taken only while busy is low. Writes made during a scan do not change the tile.
- R10: A start pulse accepted while idle clears err_sum, xfer_count and xfer_ovf in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Buffer write strobe |
| ld_addr | input | 8 | Buffer write address {row,col} |
| ld_data | input | 8 | Buffer write pixel |
| q_thresh | input | 32 | Four 8-bit quarter thresholds |
| xfer_max | input | 9 | Maximum number of transferred pixels |
| start | input | 1 | Begin a scan (taken when idle) |
| busy | output | 1 | Scan in progress |
| pred_req | output | 1 | Neighbour window valid, prediction wanted |
| nb_ul | output | 8 | Upper-left neighbour |
| nb_up | output | 8 | Upper neighbour |
| nb_ur | output | 8 | Upper-right neighbour |
| nb_lf | output | 8 | Left neighbour |
| pred_ack | input | 1 | Prediction returned this cycle |
| pred_val | input | 8 | Predicted pixel value |
| xfer_valid | output | 1 | Key pixel available |
| xfer_ready | input | 1 | Consumer accepts key pixel |
| xfer_pos | output | 8 | Key pixel position {row,col} |
| xfer_pix | output | 8 | Key pixel original value |
| done | output | 1 | One-cycle end-of-scan strobe |
| err_sum | output | 16 | Accumulated prediction error |
| xfer_count | output | 9 | Number of transferred pixels |
| xfer_ovf | output | 1 | An over-threshold pixel was refused |

## Verification
Each pixel costs six cycles of buffer reads before pred_req rises. The bench therefore does not count cycles for the window: it checks the four neighbours on the falling edge where it first sees pred_req high, and it acknowledges after a random delay of zero to two cycles. Key pixels are recorded on the falling edge where the bench raises xfer_ready while xfer_valid is high, because that is the cycle whose rising edge completes the transfer. The counters are checked as cleared one cycle after start. The final sums are read on the falling edge where done is high and read again three cycles later to show that they hold.

// File: rtl/blkpred_pkg.sv
package blkpred_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ASK,
    ST_EVAL,
    ST_PUSH
  } scan_st_t;

  localparam int unsigned NSLOT = 5;
  localparam logic [2:0] SL_UL  = 3'd0;
  localparam logic [2:0] SL_UP  = 3'd1;
  localparam logic [2:0] SL_UR  = 3'd2;
  localparam logic [2:0] SL_LF  = 3'd3;
  localparam logic [2:0] SL_CUR = 3'd4;
endpackage

// File: rtl/blkpred_buf.sv
module blkpred_buf #(
  parameter int PIX_W = 8,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [PIX_W-1:0] wd,
  input  logic [AW-1:0]    ra,
  output logic [PIX_W-1:0] rd
);
  localparam int DEPTH = 1 << AW;

  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/blkpred_win.sv
module blkpred_win
  import blkpred_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int SIDE  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [$clog2(SIDE)-1:0] row,
  input  logic [$clog2(SIDE)-1:0] col,
  output logic [2*$clog2(SIDE)-1:0] rd_addr,
  input  logic [PIX_W-1:0] rd_data,
  output logic [PIX_W-1:0] w_ul,
  output logic [PIX_W-1:0] w_up,
  output logic [PIX_W-1:0] w_ur,
  output logic [PIX_W-1:0] w_lf,
  output logic [PIX_W-1:0] w_cur,
  output logic             fill_done
);
  localparam int CW = $clog2(SIDE);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] EDGE = CW'(SIDE - 1);

  logic [2:0]       cnt;
  logic [2:0]       prev;
  logic [CW-1:0]    row_m1, col_m1, col_p1;
  logic             inb;
  logic [PIX_W-1:0] val;

  assign row_m1    = row - ONE;
  assign col_m1    = col - ONE;
  assign col_p1    = col + ONE;
  assign prev      = cnt - 3'd1;
  assign fill_done = run && (cnt == 3'(NSLOT));

  always_comb begin
    case (cnt)
      SL_UL:   rd_addr = {row_m1, col_m1};
      SL_UP:   rd_addr = {row_m1, col};
      SL_UR:   rd_addr = {row_m1, col_p1};
      SL_LF:   rd_addr = {row, col_m1};
      default: rd_addr = {row, col};
    endcase
  end

  always_comb begin
    case (prev)
      SL_UL:   inb = (row != '0) && (col != '0);
      SL_UP:   inb = (row != '0);
      SL_UR:   inb = (row != '0) && (col != EDGE);
      SL_LF:   inb = (col != '0);
      default: inb = 1'b1;
    endcase
  end

  assign val = inb ? rd_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      w_ul  <= '0;
      w_up  <= '0;
      w_ur  <= '0;
      w_lf  <= '0;
      w_cur <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else begin
      if (cnt != '0) begin
        case (prev)
          SL_UL:   w_ul  <= val;
          SL_UP:   w_up  <= val;
          SL_UR:   w_ur  <= val;
          SL_LF:   w_lf  <= val;
          default: w_cur <= val;
        endcase
      end
      cnt <= (cnt == 3'(NSLOT)) ? '0 : cnt + 3'd1;
    end
  end

  p_slot_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= 3'(NSLOT));
  p_idle_reset_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt == '0);
endmodule

// File: rtl/blkpred_acc.sv
module blkpred_acc #(
  parameter int PIX_W = 8,
  parameter int CW    = 4,
  parameter int SUM_W = 16,
  parameter int CNT_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               eval_en,
  input  logic [PIX_W-1:0]   pred,
  input  logic [PIX_W-1:0]   cur,
  input  logic [CW-1:0]      row,
  input  logic [CW-1:0]      col,
  input  logic [4*PIX_W-1:0] thr_all,
  input  logic [CNT_W-1:0]   max_xfer,
  output logic               take,
  output logic [SUM_W-1:0]   err_sum,
  output logic [CNT_W-1:0]   xfer_cnt,
  output logic               ovf
);
  logic [PIX_W-1:0] diff;
  logic [PIX_W-1:0] lim;
  logic [1:0]       quad;
  logic             over;

  assign diff = (pred > cur) ? (pred - cur) : (cur - pred);
  assign quad = {row[CW-1], col[CW-1]};
  assign lim  = thr_all[quad*PIX_W +: PIX_W];
  assign over = diff > lim;
  assign take = over && (xfer_cnt < max_xfer);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      err_sum  <= '0;
      xfer_cnt <= '0;
      ovf      <= 1'b0;
    end else if (eval_en) begin
      if (take) begin
        xfer_cnt <= xfer_cnt + 1'b1;
      end else begin
        err_sum <= err_sum + SUM_W'(diff);
        if (over) ovf <= 1'b1;
      end
    end
  end

  p_sum_mono_r3: assert property (@(posedge clk) disable iff (rst)
    !clear |=> err_sum >= $past(err_sum));
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (xfer_cnt == $past(xfer_cnt)) || (xfer_cnt == $past(xfer_cnt) + 1'b1));
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    ovf && !clear |=> ovf);
  p_clear_zero_r10: assert property (@(posedge clk) disable iff (rst)
    clear |=> (err_sum == '0) && (xfer_cnt == '0) && !ovf);
endmodule

// File: rtl/blkpred_eval.sv
module blkpred_eval
  import blkpred_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int SIDE  = 16,
  parameter int SUM_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ld_en,
  input  logic [2*$clog2(SIDE)-1:0]   ld_addr,
  input  logic [PIX_W-1:0]            ld_data,
  input  logic [4*PIX_W-1:0]          q_thresh,
  input  logic [2*$clog2(SIDE):0]     xfer_max,
  input  logic                        start,
  output logic                        busy,
  output logic                        pred_req,
  output logic [PIX_W-1:0]            nb_ul,
  output logic [PIX_W-1:0]            nb_up,
  output logic [PIX_W-1:0]            nb_ur,
  output logic [PIX_W-1:0]            nb_lf,
  input  logic                        pred_ack,
  input  logic [PIX_W-1:0]            pred_val,
  output logic                        xfer_valid,
  input  logic                        xfer_ready,
  output logic [2*$clog2(SIDE)-1:0]   xfer_pos,
  output logic [PIX_W-1:0]            xfer_pix,
  output logic                        done,
  output logic [SUM_W-1:0]            err_sum,
  output logic [2*$clog2(SIDE):0]     xfer_count,
  output logic                        xfer_ovf
);
  localparam int CW    = $clog2(SIDE);
  localparam int AW    = 2 * CW;
  localparam int CNT_W = AW + 1;

  scan_st_t         st;
  logic [AW-1:0]    pos;
  logic [CW-1:0]    row, col;
  logic [AW-1:0]    rd_addr;
  logic [PIX_W-1:0] rd_data;
  logic [PIX_W-1:0] cur_pix;
  logic [PIX_W-1:0] pred_q;
  logic             fill_done;
  logic             take;
  logic             last;
  logic             clear;

  assign row   = pos[AW-1:CW];
  assign col   = pos[CW-1:0];
  assign last  = &pos;
  assign busy  = (st != ST_IDLE);
  assign clear = (st == ST_IDLE) && start;

  blkpred_buf #(.PIX_W(PIX_W), .AW(AW)) buf_i (
    .clk (clk),
    .we  (ld_en && (st == ST_IDLE)),
    .wa  (ld_addr),
    .wd  (ld_data),
    .ra  (rd_addr),
    .rd  (rd_data)
  );

  blkpred_win #(.PIX_W(PIX_W), .SIDE(SIDE)) win_i (
    .clk       (clk),
    .rst       (rst),
    .run       (st == ST_FETCH),
    .row       (row),
    .col       (col),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .w_ul      (nb_ul),
    .w_up      (nb_up),
    .w_ur      (nb_ur),
    .w_lf      (nb_lf),
    .w_cur     (cur_pix),
    .fill_done (fill_done)
  );

  blkpred_acc #(.PIX_W(PIX_W), .CW(CW), .SUM_W(SUM_W), .CNT_W(CNT_W)) acc_i (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .eval_en  (st == ST_EVAL),
    .pred     (pred_q),
    .cur      (cur_pix),
    .row      (row),
    .col      (col),
    .thr_all  (q_thresh),
    .max_xfer (xfer_max),
    .take     (take),
    .err_sum  (err_sum),
    .xfer_cnt (xfer_count),
    .ovf      (xfer_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      pos        <= '0;
      pred_req   <= 1'b0;
      pred_q     <= '0;
      xfer_valid <= 1'b0;
      xfer_pos   <= '0;
      xfer_pix   <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            pos <= '0;
            st  <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (fill_done) begin
            pred_req <= 1'b1;
            st       <= ST_ASK;
          end
        end
        ST_ASK: begin
          if (pred_ack) begin
            pred_q   <= pred_val;
            pred_req <= 1'b0;
            st       <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (take) begin
            xfer_valid <= 1'b1;
            xfer_pos   <= pos;
            xfer_pix   <= cur_pix;
            st         <= ST_PUSH;
          end else if (last) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            pos <= pos + 1'b1;
            st  <= ST_FETCH;
          end
        end
        ST_PUSH: begin
          if (xfer_ready) begin
            xfer_valid <= 1'b0;
            if (last) begin
              done <= 1'b1;
              st   <= ST_IDLE;
            end else begin
              pos <= pos + 1'b1;
              st  <= ST_FETCH;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_push_hold_r7: assert property (@(posedge clk) disable iff (rst)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_pos) && $stable(xfer_pix));
  p_no_ask_in_push_r7: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> !pred_req);
  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    pred_req && !pred_ack |=> pred_req && $stable(nb_ul) && $stable(nb_up)
                              && $stable(nb_ur) && $stable(nb_lf));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !xfer_valid && !pred_req);
  p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> $stable(err_sum) && $stable(xfer_count) && $stable(xfer_ovf));
endmodule

// File: tb/blkpred_eval_tb.sv
`timescale 1ns/1ps
module blkpred_eval_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic [31:0] q_thresh = '0;
  logic [8:0]  xfer_max = '0;
  logic        start = 1'b0;
  logic        busy, pred_req, pred_ack, xfer_valid, xfer_ready, done, xfer_ovf;
  logic [7:0]  nb_ul, nb_up, nb_ur, nb_lf, pred_val, xfer_pos, xfer_pix;
  logic [15:0] err_sum;
  logic [8:0]  xfer_count;

  always #2.5 clk = ~clk;

  blkpred_eval dut_i (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .q_thresh(q_thresh), .xfer_max(xfer_max), .start(start), .busy(busy),
    .pred_req(pred_req), .nb_ul(nb_ul), .nb_up(nb_up), .nb_ur(nb_ur), .nb_lf(nb_lf),
    .pred_ack(pred_ack), .pred_val(pred_val), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_pos(xfer_pos), .xfer_pix(xfer_pix), .done(done),
    .err_sum(err_sum), .xfer_count(xfer_count), .xfer_ovf(xfer_ovf)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0] img [256];
  logic [7:0] exp_pos [256];
  logic [7:0] exp_pix [256];
  logic [7:0] got_pos [256];
  logic [7:0] got_pix [256];
  int got_n   = 0;
  int req_idx = 0;
  int e_sum, e_cnt;
  bit e_ovf;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [7:0] pf(logic [7:0] ul, logic [7:0] up, logic [7:0] ur, logic [7:0] lf);
    logic [8:0] s;
    s = {1'b0, up} + {1'b0, lf};
    return s[8:1] ^ (ur & 8'h0F) ^ (ul >> 5);
  endfunction

  function automatic logic [7:0] nbv(int r, int c);
    if (r < 0 || c < 0 || c > 15) return 8'd0;
    return img[r*16 + c];
  endfunction

  task automatic model(input logic [31:0] thr, input int mx);
    e_sum = 0; e_cnt = 0; e_ovf = 0;
    for (int k = 0; k < 256; k++) begin
      int r, c, d, q, t;
      logic [7:0] p, o;
      r = k / 16; c = k % 16;
      p = pf(nbv(r-1, c-1), nbv(r-1, c), nbv(r-1, c+1), nbv(r, c-1));
      o = img[k];
      d = (p > o) ? int'(p - o) : int'(o - p);
      q = (r / 8) * 2 + (c / 8);
      t = int'(thr[q*8 +: 8]);
      if (d > t && e_cnt < mx) begin
        exp_pos[e_cnt] = 8'(k);
        exp_pix[e_cnt] = o;
        e_cnt++;
      end else begin
        if (d > t) e_ovf = 1;
        e_sum += d;
      end
    end
  endtask

  // predictor model: checks the window (R2) and answers after 0..2 cycles
  initial begin
    pred_ack = 1'b0; pred_val = '0;
    forever begin
      @(negedge clk);
      if (pred_req && !pred_ack) begin
        int r, c;
        r = req_idx / 16; c = req_idx % 16;
        chk(req_idx < 256 && nb_ul == nbv(r-1, c-1) && nb_up == nbv(r-1, c) &&
            nb_ur == nbv(r-1, c+1) && nb_lf == nbv(r, c-1), "R2 window", int'(nb_up), int'(nbv(r-1, c)));
        repeat ($urandom_range(2)) @(negedge clk);
        pred_val = pf(nb_ul, nb_up, nb_ur, nb_lf);
        pred_ack = 1'b1;
        @(negedge clk);
        pred_ack = 1'b0;
        req_idx++;
      end
    end
  end

  // key pixel consumer with random back-pressure (R7)
  initial begin
    xfer_ready = 1'b0;
    forever begin
      @(negedge clk);
      xfer_ready = ($urandom_range(2) != 0);
      if (xfer_valid && xfer_ready) begin
        if (got_n < 256) begin
          got_pos[got_n] = xfer_pos;
          got_pix[got_n] = xfer_pix;
        end
        got_n++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic load_img();
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 8'(a); ld_data = img[a];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_scan(input logic [31:0] thr, input int mx, input bit scribble, input string tag);
    int t;
    model(thr, mx);
    q_thresh = thr; xfer_max = 9'(mx);
    req_idx = 0; got_n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    chk(err_sum == 0 && xfer_count == 0 && !xfer_ovf, "R10 cleared on start",
        int'(err_sum) + int'(xfer_count) + int'(xfer_ovf), 0);
    t = 0;
    fork
      begin
        if (scribble) begin
          for (int a = 0; a < 256; a++) begin
            ld_en = 1'b1; ld_addr = 8'(a); ld_data = ~img[a];
            @(negedge clk);
          end
          ld_en = 1'b0;
        end
      end
      begin
        while (!done && t < 20000) begin
          @(negedge clk);
          t++;
        end
      end
    join
    chk(done == 1'b1, {"R8 done seen ", tag}, int'(done), 1);
    chk(busy == 1'b0, {"R8 idle at done ", tag}, int'(busy), 0);
    chk(int'(err_sum) == e_sum, {"R3 err_sum ", tag}, int'(err_sum), e_sum);
    chk(int'(xfer_count) == e_cnt, {"R5 xfer_count ", tag}, int'(xfer_count), e_cnt);
    chk(xfer_ovf == e_ovf, {"R6 overflow ", tag}, int'(xfer_ovf), int'(e_ovf));
    chk(got_n == e_cnt, {"R7 key pixels seen ", tag}, got_n, e_cnt);
    chk(req_idx == 256, {"R2 request count ", tag}, req_idx, 256);
    for (int i = 0; i < e_cnt && i < got_n; i++)
      chk(got_pos[i] == exp_pos[i] && got_pix[i] == exp_pix[i], {"R5 key pixel ", tag},
          int'({got_pos[i], got_pix[i]}), int'({exp_pos[i], exp_pix[i]}));
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && int'(err_sum) == e_sum && int'(xfer_count) == e_cnt,
        {"R8 results hold ", tag}, int'(err_sum), e_sum);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !pred_req && !xfer_valid && !done, "R1 idle outputs",
        int'({busy, pred_req, xfer_valid, done}), 0);
    chk(err_sum == 0 && xfer_count == 0 && !xfer_ovf, "R1 result regs",
        int'(err_sum) + int'(xfer_count), 0);

    for (int a = 0; a < 256; a++) img[a] = 8'($urandom_range(255));
    load_img();
    run_scan(32'hFFFF_FFFF, 256, 1'b0, "R3 no-threshold");
    run_scan({8'($urandom_range(40)), 8'($urandom_range(40)), 8'($urandom_range(40)),
              8'($urandom_range(40))}, 256, 1'b0, "R4 random thresholds");
    run_scan(32'hFFFF_FF00, 256, 1'b0, "R4 quarter0 only");
    for (int i = 0; i < got_n && i < 256; i++)
      chk(got_pos[i][7] == 1'b0 && got_pos[i][3] == 1'b0, "R4 top-left position", int'(got_pos[i]), 0);
    run_scan(32'h00FF_FFFF, 256, 1'b0, "R4 quarter3 only");
    for (int i = 0; i < got_n && i < 256; i++)
      chk(got_pos[i][7] == 1'b1 && got_pos[i][3] == 1'b1, "R4 bottom-right position", int'(got_pos[i]), 136);
    run_scan(32'h0000_0000, 10, 1'b0, "R6 cap ten");
    run_scan(32'h0000_0000, 0, 1'b0, "R6 cap zero");
    run_scan(32'h1010_1010, 256, 1'b1, "R9 writes during scan");
    run_scan(32'h1010_1010, 256, 1'b0, "R9 buffer intact");

    for (int a = 0; a < 256; a++) img[a] = 8'd100;
    load_img();
    run_scan(32'h3232_3232, 40, 1'b0, "R5 flat tile");
    for (int a = 0; a < 256; a++) img[a] = 8'(a * 7);
    load_img();
    run_scan(32'h0820_4002, 256, 1'b0, "R5 ramp tile");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule